// File: doc/BRIEF.md
# Hall-commutated three-phase bridge PWM controller

This block turns three digitised Hall sensor bits into six gate enables for a three-phase half-bridge inverter, with one high-side and one low-side enable per phase. In every legal rotor sector one phase sources current through its high switch, one sinks it through its low switch, and the third floats. Motor torque is set by chopping only the sinking low switch with a PWM waveform. The high switch stays fully on for its whole sector.

The PWM waveform comes from an internal up-counter that advances on an external carrier tick and restarts after a programmable period. The low switch conducts while the count is below a duty compare value. While the speed loop reports phase lock, that compare value is halved. It is always clamped to the period. A current-limit trip ends the on-time for the rest of the carrier period, but only once a blanking interval after switch-on has passed, so that the recovery spike at turn-on is not mistaken for overcurrent. Start/stop, a braking request with a choice between coasting and reverse torque, fault flags and a programmable dead time between the two switches of a phase complete the control.

Top module: `hall_pwm_commutator`

## Requirements
- R1: With `hall_i` = {IN3,IN2,IN1}, running and not braking, the phases (1,2,3) are driven as follows, where H is high switch on, L is low switch on and F is floating: 3'b101→L,H,F; 3'b001→L,F,H; 3'b011→F,L,H; 3'b010→H,L,F; 3'b110→H,F,L; 3'b100→F,H,L. Bit k-1 of `hi_en_o` and of `lo_en_o` belongs to phase k.
- R2: The Hall codes 3'b000 and 3'b111 turn all six enables off.
- R3: While `stop_i` is 1 all six enables are off. Outputs are registered, so requests reach the pins one clock later.
- R4: While `brake_i` is 1 and `coast_sel_i` is 0, every phase driven H in the R1 table is driven L and every phase driven L is driven H (reverse torque).
- R5: While `brake_i` is 1 and `coast_sel_i` is 1, all six enables are off.
- R6: The carrier counter advances by one on each `carrier_tick_i` and restarts at 0 on the tick after it reaches `period_i`. A low switch may only conduct while the count is below the effective duty. High switches are never chopped.
- R7: The effective duty is clamped to `period_i`.
- R8: While `locked_i` is 1 the effective duty is `duty_i` shifted right by one.
- R9: A `ilim_trip_i` that is high after the on-time has lasted BLANK_CYC clocks turns the low switch off until the carrier restarts. A trip during the first BLANK_CYC clocks of an on-time has no effect.
- R10: Any of `flt_therm_i`, `flt_uv_i` or `flt_lockprot_i` forces all low enables off. The high enables keep following the table.
- R11: Within a phase, when one switch turns off, the opposite switch stays off for at least `dead_i`+1 clocks. The same switch may turn back on without waiting.
- R12: Reset clears all enables. At no time are both switches of a phase on, and at most one high and one low enable are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall bits {IN3,IN2,IN1} |
| carrier_tick_i | input | 1 | Carrier counter advance strobe |
| period_i | input | CNT_W | Carrier terminal count |
| duty_i | input | CNT_W | Duty compare command |
| locked_i | input | 1 | Speed loop phase-locked flag (halves duty) |
| stop_i | input | 1 | 1 = stop, 0 = run |
| brake_i | input | 1 | Deceleration request |
| coast_sel_i | input | 1 | Braking style: 1 coast, 0 reverse torque |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| flt_therm_i | input | 1 | Over-temperature fault |
| flt_uv_i | input | 1 | Supply undervoltage fault |
| flt_lockprot_i | input | 1 | Stalled-rotor protection fault |
| dead_i | input | DT_W | Dead time in clocks |
| hi_en_o | output | 3 | High-side gate enables, bit k-1 = phase k |
| lo_en_o | output | 3 | Low-side gate enables, bit k-1 = phase k |

## Verification
On every cycle the assertions check that the bridge never shoots through, that stop, illegal Hall codes and faults clear the enables one clock after they appear, that a low switch only turns on after a cycle in which the PWM gate was open, and that an opposite switch waits out the dead time. The exact commutation pattern for each sector, the reverse-torque swap, the duty clamp and halving, the carrier wrap and the blanking of the current-limit trip depend on numeric timing. Only the bench's cycle-by-cycle reference model, run through these scenarios, can show them.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
  } bridge_t;

  // Sector decode; bit k-1 is phase k, hall = {IN3,IN2,IN1}.
  function automatic bridge_t hall_decode(input logic [2:0] hall, input logic reverse);
    bridge_t b;
    case (hall)
      3'b101:  b = '{hi: 3'b010, lo: 3'b001};
      3'b001:  b = '{hi: 3'b100, lo: 3'b001};
      3'b011:  b = '{hi: 3'b100, lo: 3'b010};
      3'b010:  b = '{hi: 3'b001, lo: 3'b010};
      3'b110:  b = '{hi: 3'b001, lo: 3'b100};
      3'b100:  b = '{hi: 3'b010, lo: 3'b100};
      default: b = '{hi: 3'b000, lo: 3'b000};
    endcase
    if (reverse) b = '{hi: b.lo, lo: b.hi};
    return b;
  endfunction

endpackage

// File: rtl/hpc_carrier.sv
module hpc_carrier #(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             locked_i,
  input  logic             ilim_i,
  output logic             raw_o,
  output logic             wrap_o,
  output logic             gate_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_MAX = BW'(BLANK_CYC);

  function automatic logic [CNT_W-1:0] eff_duty(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] p,
                                                input logic             half);
    logic [CNT_W-1:0] x;
    x = half ? (d >> 1) : d;
    return (x > p) ? p : x;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    blank_q;
  logic             cut_q;
  logic             armed;

  assign wrap_o = tick_i && (cnt_q >= period_i);
  assign raw_o  = cnt_q < eff_duty(duty_i, period_i, locked_i);
  assign armed  = (blank_q == BLANK_MAX);
  assign gate_o = raw_o && !cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= '0;
      cut_q   <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      if (!raw_o)       blank_q <= '0;
      else if (!armed)  blank_q <= blank_q + 1'b1;
      if (wrap_o)                          cut_q <= 1'b0;
      else if (raw_o && ilim_i && armed)   cut_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hpc_commutate.sv
module hpc_commutate
  import hpc_pkg::*;
(
  input  logic [2:0] hall_i,
  input  logic       stop_i,
  input  logic       brake_i,
  input  logic       coast_sel_i,
  input  logic       fault_i,
  input  logic       gate_i,
  output bridge_t    req_o
);
  logic    illegal;
  logic    all_off;
  bridge_t sector;

  assign illegal = (hall_i == 3'b000) || (hall_i == 3'b111);
  assign all_off = stop_i || illegal || (brake_i && coast_sel_i);
  assign sector  = hall_decode(hall_i, brake_i && !coast_sel_i);

  always_comb begin
    req_o.hi = all_off ? 3'b000 : sector.hi;
    req_o.lo = (all_off || fault_i) ? 3'b000 : (sector.lo & {3{gate_i}});
  end
endmodule

// File: rtl/hpc_deadtime.sv
module hpc_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_hi_i,
  input  logic            req_lo_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic [DT_W-1:0] dt_q;
  logic            last_lo_q;
  logic            hi_ok;
  logic            lo_ok;

  assign hi_ok = req_hi_i && !lo_o && ((dt_q == '0) || !last_lo_q);
  assign lo_ok = req_lo_i && !hi_o && ((dt_q == '0) ||  last_lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o      <= 1'b0;
      lo_o      <= 1'b0;
      dt_q      <= '0;
      last_lo_q <= 1'b0;
    end else begin
      hi_o <= hi_ok;
      lo_o <= lo_ok;
      if (hi_o && !hi_ok) begin
        dt_q      <= dead_i;
        last_lo_q <= 1'b0;
      end else if (lo_o && !lo_ok) begin
        dt_q      <= dead_i;
        last_lo_q <= 1'b1;
      end else if (dt_q != '0) begin
        dt_q <= dt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hall_pwm_commutator.sv
module hall_pwm_commutator
  import hpc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DT_W      = 4,
  parameter int BLANK_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hall_i,
  input  logic             carrier_tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             locked_i,
  input  logic             stop_i,
  input  logic             brake_i,
  input  logic             coast_sel_i,
  input  logic             ilim_trip_i,
  input  logic             flt_therm_i,
  input  logic             flt_uv_i,
  input  logic             flt_lockprot_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [2:0]       hi_en_o,
  output logic [2:0]       lo_en_o
);
  localparam int PHASES = 3;

  logic    pwm_raw;
  logic    pwm_gate;
  logic    carrier_wrap;
  logic    any_fault;
  bridge_t req;

  assign any_fault = flt_therm_i || flt_uv_i || flt_lockprot_i;

  hpc_carrier #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (carrier_tick_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .locked_i (locked_i),
    .ilim_i   (ilim_trip_i),
    .raw_o    (pwm_raw),
    .wrap_o   (carrier_wrap),
    .gate_o   (pwm_gate)
  );

  hpc_commutate u_commutate (
    .hall_i      (hall_i),
    .stop_i      (stop_i),
    .brake_i     (brake_i),
    .coast_sel_i (coast_sel_i),
    .fault_i     (any_fault),
    .gate_i      (pwm_gate),
    .req_o       (req)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    hpc_deadtime #(.DT_W(DT_W)) u_dt (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_hi_i (req.hi[p]),
      .req_lo_i (req.lo[p]),
      .dead_i   (dead_i),
      .hi_o     (hi_en_o[p]),
      .lo_o     (lo_en_o[p])
    );
  end
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      hall_i,
  input logic            stop_i,
  input logic            fault_i,
  input logic            gate_i,
  input logic [DT_W-1:0] dead_i,
  input logic [2:0]      hi_en,
  input logic [2:0]      lo_en
);
  logic [DT_W:0] gap_q  [3];
  logic [2:0]    lo_last_q;

  for (genvar i = 0; i < 3; i++) begin : g_chk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q[i]     <= '0;
        lo_last_q[i] <= 1'b0;
      end else begin
        if (hi_en[i] || lo_en[i]) gap_q[i] <= '0;
        else if (gap_q[i] != '1)  gap_q[i] <= gap_q[i] + 1'b1;
        if (lo_en[i])      lo_last_q[i] <= 1'b1;
        else if (hi_en[i]) lo_last_q[i] <= 1'b0;
      end
    end

    p_no_shoot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_en[i] && lo_en[i]));

    p_dead_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_en[i]) && lo_last_q[i]) |-> (gap_q[i] > {1'b0, dead_i}));

    p_dead_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lo_en[i]) && !lo_last_q[i] && $past(hi_en[i] || gap_q[i] != '0))
        |-> (gap_q[i] > {1'b0, dead_i}));

    p_lo_needs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_en[i]) |-> $past(gate_i));
  end

  p_one_each_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hi_en) <= 1) && ($countones(lo_en) <= 1));

  p_stop_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (hi_en == 3'b000 && lo_en == 3'b000));

  p_illegal_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_i == 3'b000 || hall_i == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000));

  p_fault_lo_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (lo_en == 3'b000));
endmodule

bind hall_pwm_commutator hpc_checker #(.DT_W(DT_W)) u_hpc_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .hall_i  (hall_i),
  .stop_i  (stop_i),
  .fault_i (any_fault),
  .gate_i  (pwm_gate),
  .dead_i  (dead_i),
  .hi_en   (hi_en_o),
  .lo_en   (lo_en_o)
);

// File: tb/test_hall_pwm_commutator.sv
`timescale 1ns/1ps
module test_hall_pwm_commutator;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int BLANK = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [2:0]       hall = 3'b101;
  logic             tick = 1'b0;
  logic             tick_en = 1'b0;
  logic             tick_div = 1'b0;
  logic [CNT_W-1:0] period = 8'd20;
  logic [CNT_W-1:0] duty = 8'd0;
  logic             locked = 1'b0;
  logic             stop = 1'b1;
  logic             brake = 1'b0;
  logic             coast = 1'b0;
  logic             ilim = 1'b0;
  logic             f_th = 1'b0, f_uv = 1'b0, f_lp = 1'b0;
  logic [DT_W-1:0]  dead = '0;
  logic [2:0]       hi_en, lo_en;

  hall_pwm_commutator #(.CNT_W(CNT_W), .DT_W(DT_W), .BLANK_CYC(BLANK)) i_hall_pwm_commutator (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .carrier_tick_i(tick),
    .period_i(period), .duty_i(duty), .locked_i(locked), .stop_i(stop),
    .brake_i(brake), .coast_sel_i(coast), .ilim_trip_i(ilim),
    .flt_therm_i(f_th), .flt_uv_i(f_uv), .flt_lockprot_i(f_lp),
    .dead_i(dead), .hi_en_o(hi_en), .lo_en_o(lo_en)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R12";
  bit    done = 1'b0;
  int    cyc = 0;

  // Phase letter per sector: 0 float, 1 high, 2 low. Index = phase-1.
  function automatic void sector_codes(input logic [2:0] h, output int c[3]);
    case (h)
      3'b101: c = '{2, 1, 0};
      3'b001: c = '{2, 0, 1};
      3'b011: c = '{0, 2, 1};
      3'b010: c = '{1, 2, 0};
      3'b110: c = '{1, 0, 2};
      3'b100: c = '{0, 1, 2};
      default: c = '{0, 0, 0};
    endcase
  endfunction

  // Behavioural reference model state
  int m_cnt = 0, m_blank = 0;
  bit m_cut = 0;
  bit m_hi[3] = '{0, 0, 0};
  bit m_lo[3] = '{0, 0, 0};
  int m_off[3] = '{1000, 1000, 1000};
  bit m_lastlo[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_blank = 0; m_cut = 0;
      for (int i = 0; i < 3; i++) begin
        m_hi[i] = 0; m_lo[i] = 0; m_off[i] = 1000; m_lastlo[i] = 0;
      end
    end else begin
      int  eff, c[3];
      bit  raw, gate, wrap, off_all, flt, rev;
      bit  rh, rl, gh, gl;
      eff = locked ? int'(duty) / 2 : int'(duty);
      if (eff > int'(period)) eff = int'(period);
      raw  = m_cnt < eff;
      gate = raw && !m_cut;
      wrap = tick && (m_cnt >= int'(period));
      sector_codes(hall, c);
      rev = brake && !coast;
      off_all = stop || (brake && coast) || hall == 3'b000 || hall == 3'b111;
      flt = f_th || f_uv || f_lp;
      for (int i = 0; i < 3; i++) begin
        int code;
        code = c[i];
        if (rev && code != 0) code = 3 - code;
        rh = !off_all && code == 1;
        rl = !off_all && !flt && code == 2 && gate;
        gh = rh && !m_lo[i] && (!m_lastlo[i] || m_off[i] >= int'(dead));
        gl = rl && !m_hi[i] && ( m_lastlo[i] || m_off[i] >= int'(dead));
        if (m_hi[i] && !gh)      begin m_off[i] = 0; m_lastlo[i] = 0; end
        else if (m_lo[i] && !gl) begin m_off[i] = 0; m_lastlo[i] = 1; end
        else if (m_off[i] < 1000) m_off[i]++;
        m_hi[i] = gh; m_lo[i] = gl;
      end
      if (wrap) m_cut = 0;
      else if (raw && ilim && m_blank >= BLANK) m_cut = 1;
      m_blank = raw ? ((m_blank < BLANK) ? m_blank + 1 : BLANK) : 0;
      if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
    end
  end

  // Every-cycle comparison, carrier tick generation, watchdog
  always @(negedge clk) begin
    logic [2:0] eh, el;
    cyc++;
    tick_div <= ~tick_div;
    tick     <= tick_en && tick_div;
    if (rst_n && !done) begin
      for (int i = 0; i < 3; i++) begin eh[i] = m_hi[i]; el[i] = m_lo[i]; end
      checks++;
      if (hi_en !== eh || lo_en !== el) begin
        failures++;
        $display("FAIL %s cycle %0d: hi=%b lo=%b expected hi=%b lo=%b",
                 cur_req, cyc, hi_en, lo_en, eh, el);
      end
    end
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_hi(input logic [2:0] h);
    int c[3];
    logic [2:0] r;
    sector_codes(h, c);
    for (int i = 0; i < 3; i++) r[i] = (c[i] == 1);
    return r;
  endfunction

  function automatic logic [2:0] exp_lo(input logic [2:0] h);
    int c[3];
    logic [2:0] r;
    sector_codes(h, c);
    for (int i = 0; i < 3; i++) r[i] = (c[i] == 2);
    return r;
  endfunction

  initial begin
    logic [2:0] seq [6];
    seq = '{3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100};
    run(4);
    chk("R12 reset hi", hi_en, 3'b000);
    chk("R12 reset lo", lo_en, 3'b000);
    rst_n = 1'b1;
    run(4);
    cur_req = "R3";
    chk("R3 stopped hi", hi_en, 3'b000);

    // R1 / R7: forward sectors, oversized duty clamped to the period
    cur_req = "R1";
    tick_en = 1'b1; duty = 8'd200; stop = 1'b0;
    for (int s = 0; s < 6; s++) begin
      hall = seq[s];
      run(30);
      chk("R1 sector high side", hi_en, exp_hi(seq[s]));
      checks++;
      if ((lo_en & ~exp_lo(seq[s])) != 0) begin
        failures++;
        $display("FAIL R1 low side: actual=%b expected subset of %b", lo_en, exp_lo(seq[s]));
      end
    end
    cur_req = "R7";
    run(100);

    // R6 / R8: partial duty, then halved while locked
    cur_req = "R6"; duty = 8'd12; hall = 3'b011;
    run(120);
    cur_req = "R8"; locked = 1'b1;
    run(120);
    locked = 1'b0;

    // R2: illegal codes
    cur_req = "R2";
    hall = 3'b000; run(10);
    chk("R2 hall 000 hi", hi_en, 3'b000); chk("R2 hall 000 lo", lo_en, 3'b000);
    hall = 3'b111; run(10);
    chk("R2 hall 111 hi", hi_en, 3'b000); chk("R2 hall 111 lo", lo_en, 3'b000);
    hall = 3'b010; run(40);

    // R10: each fault in turn
    cur_req = "R10"; duty = 8'd200;
    f_th = 1'b1; run(20);
    chk("R10 thermal lo", lo_en, 3'b000); chk("R10 thermal hi", hi_en, exp_hi(3'b010));
    f_th = 1'b0; f_uv = 1'b1; run(20);
    chk("R10 undervoltage lo", lo_en, 3'b000);
    f_uv = 1'b0; f_lp = 1'b1; run(20);
    chk("R10 lock protection lo", lo_en, 3'b000);
    f_lp = 1'b0; run(40);

    // R9: constant trip (cut after blanking) and short trips inside blanking
    cur_req = "R9"; duty = 8'd15; hall = 3'b110;
    ilim = 1'b1; run(200);
    ilim = 1'b0; run(60);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk iff (lo_en != 3'b000));
      ilim = 1'b1; run(2); ilim = 1'b0; run(40);
    end

    // R3 stop, then set dead time while stopped
    cur_req = "R3"; stop = 1'b1; run(3);
    chk("R3 stop hi", hi_en, 3'b000); chk("R3 stop lo", lo_en, 3'b000);
    dead = 4'd3; run(20);
    stop = 1'b0; duty = 8'd200; hall = 3'b101; run(60);

    // R4 / R11: reverse torque swaps H and L with dead time
    cur_req = "R4"; brake = 1'b1; coast = 1'b0;
    run(2);
    checks++;
    if (hi_en[0] !== 1'b0) begin
      failures++;
      $display("FAIL R11 phase1 high too early: actual=%b expected=0", hi_en[0]);
    end
    run(40);
    chk("R4 reverse hi", hi_en, exp_lo(3'b101));
    for (int s = 0; s < 6; s++) begin hall = seq[s]; run(25); end

    // R5: coasting
    cur_req = "R5"; coast = 1'b1; run(10);
    chk("R5 coast hi", hi_en, 3'b000); chk("R5 coast lo", lo_en, 3'b000);

    // R11: zero and maximum dead time across brake toggles
    cur_req = "R11"; brake = 1'b0; stop = 1'b1; run(5); dead = 4'd0; run(20); stop = 1'b0;
    for (int s = 0; s < 6; s++) begin hall = seq[s]; brake = s[0]; coast = 1'b0; run(30); end
    stop = 1'b1; run(5); dead = 4'd15; run(30); stop = 1'b0; brake = 1'b0;
    for (int s = 0; s < 6; s++) begin hall = seq[s]; brake = s[0]; run(50); end
    stop = 1'b1; run(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule